// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of a serial port. A host writes characters into a one-entry holding buffer. The block then moves each character into an output shift register, frames it, and shifts it out on a single line. The holding buffer and the shift register are separate stages. Because of this, the host can write the next character while the current one is still on the line. Back-to-back characters then leave with no idle gap between them.

There are two line modes. Asynchronous mode frames each character with a start bit, optional parity and stop bits, and applies a selectable divide factor to the transmit clock. Synchronous mode sends bare data bits at one bit per transmit clock. When nothing is pending and the block is enabled, synchronous mode fills the line with a programmable sync character.

The transmit clock is supplied as a one-cycle strobe `txc_i` in the system clock domain. The host sees two flags:
- a ready flag, which says the holding buffer can take a character;
- an empty flag, which says no written character remains to be sent.

Flow control comes from a clear-to-send input and an enable input. Either one stops new acceptance and stops sync fill. Neither one cuts short data that has already been written.

Top module: `usart_tx_core`

## Requirements
- R1: A write with `wr_en_i` high while the holding buffer is free stores `wr_data_i`. The stored character moves into the shift register in the cycle after it is written if the line is idle. Otherwise it moves in at the clock where the current frame's last bit ends, so two consecutive characters leave with no idle bit between them.
- R2: `tx_rdy_o` is high only when `tx_en_i` is 1, `cts_n_i` is 0 and the holding buffer is free. It falls in the cycle after an accepted write and rises again when the character moves into the shift register.
- R3: `tx_empty_o` is high exactly when neither the holding buffer nor the shift register holds a written character. A sync-fill character being sent counts as empty.
- R4: An asynchronous frame is sent as follows. The line idles at 1. The frame is a 0 start bit, then 5 + `char_len_i` data bits with bit 0 first, then the parity bit if `par_en_i` is 1, then one stop bit of 1, or two if `stop2_i` is 1.
- R5: The parity bit is the XOR of the sent data bits when `par_odd_i` is 0 (even parity). It is the inverse of that XOR when `par_odd_i` is 1 (odd parity).
- R6: In asynchronous mode, each bit lasts a number of `txc_i` strobes set by `rate_sel_i`: 1 for 2'b00, 16 for 2'b01, 64 for 2'b10. The value 2'b11 acts as 1.
- R7: With `mode_sync_i` at 1, a character is sent as its data bits, then parity if enabled. There is no start bit and no stop bit. Each bit lasts one `txc_i` strobe whatever the value of `rate_sel_i`.
- R8: In synchronous mode, with `tx_en_i` at 1 and `cts_n_i` at 0 and no character pending, `sync_char_i` is sent repeatedly using the same length and parity settings. A written character is sent after the sync character in progress. When disabled and idle, the line is 1.
- R9: Dropping `tx_en_i` or raising `cts_n_i` does not truncate or discard characters already written. Both the one in the shift register and the one in the holding buffer go out in full.
- R10: After reset, `txd_o` is 1, `tx_empty_o` is 1, and `tx_rdy_o` is 0 until `tx_en_i` is 1 with `cts_n_i` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe for the holding buffer |
| wr_data_i | input | DATA_W | Character to send |
| txc_i | input | 1 | Transmit clock strobe, one cycle wide |
| cts_n_i | input | 1 | Clear-to-send, active low |
| tx_en_i | input | 1 | Transmit enable command |
| mode_sync_i | input | 1 | 1 = synchronous, 0 = asynchronous |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Append parity bit |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop2_i | input | 1 | Two stop bits in asynchronous mode |
| rate_sel_i | input | 2 | Asynchronous rate factor select |
| sync_char_i | input | DATA_W | Fill character for synchronous mode |
| txd_o | output | 1 | Serial data line |
| tx_rdy_o | output | 1 | Holding buffer can accept a write |
| tx_empty_o | output | 1 | No written character left to send |

## Verification
The bench aims at the frame boundary, where a second character written during the first must start on the very next bit. A design that frees the buffer late, or inserts an idle bit there, breaks the captured bit stream. Flow control is dropped in mid-frame with a character still waiting. A design that aborts on clear-to-send or enable would lose the queued frame or leave the line mid-character. The synchronous test enables fill, writes during the first sync character, and expects data exactly after it with fill resuming afterwards; it also leaves a 16x rate selected, which a design applying the factor in synchronous mode would stretch. Odd and even parity, one and two stop bits, short characters and the slow rate factors are walked through a vector table.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

   typedef enum logic [1:0] {
      RATE_X1   = 2'b00,
      RATE_X16  = 2'b01,
      RATE_X64  = 2'b10,
      RATE_RSVD = 2'b11
   } rate_sel_e;

   localparam int unsigned MIN_CHAR_BITS = 5;

endpackage

// File: rtl/utx_rate_div.sv
module utx_rate_div
   import usart_tx_pkg::*;
#(
   parameter int unsigned RATE_MID = 16,
   parameter int unsigned RATE_HI  = 64,
   localparam int unsigned DIV_W   = $clog2(RATE_HI)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       strobe_i,
   input  logic       restart_i,
   input  logic       sync_mode_i,
   input  logic [1:0] rate_sel_i,
   output logic       tick_o
);

   rate_sel_e        sel;
   logic [DIV_W-1:0] factor_m1;
   logic [DIV_W-1:0] cnt_q;

   assign sel = rate_sel_e'(rate_sel_i);

   always_comb begin
      factor_m1 = '0;
      if (!sync_mode_i) begin
         case (sel)
            RATE_X16: factor_m1 = DIV_W'(RATE_MID - 1);
            RATE_X64: factor_m1 = DIV_W'(RATE_HI - 1);
            default:  factor_m1 = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (strobe_i) begin
         cnt_q <= (cnt_q == factor_m1) ? '0 : cnt_q + DIV_W'(1);
      end
   end

   assign tick_o = strobe_i && (cnt_q == factor_m1);

endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              take_i,
   input  logic              gate_i,
   output logic              full_o,
   output logic [DATA_W-1:0] data_o,
   output logic              rdy_o
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign accept = wr_en_i && !full_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         full_q <= (full_q && !take_i) || accept;
         if (accept) data_q <= wr_data_i;
      end
   end

   assign full_o = full_q;
   assign data_o = data_q;
   assign rdy_o  = gate_i && !full_q;

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import usart_tx_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   localparam int unsigned FRAME_W = DATA_W + 4,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_data_i,
   input  logic              sync_mode_i,
   input  logic              gate_i,
   input  logic [DATA_W-1:0] sync_char_i,
   input  logic [1:0]        char_len_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              stop2_i,
   output logic              txd_o,
   output logic              take_o,
   output logic              load_o,
   output logic              data_busy_o
);

   logic [FRAME_W-1:0] sreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               busy_q;
   logic               is_data_q;

   logic [DATA_W-1:0]  src;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic [CNT_W-1:0]   dlen;
   logic [CNT_W-1:0]   pos;
   logic               par_acc;
   logic               want;
   logic               done;

   // frame assembly, bit 0 leaves first
   always_comb begin
      src     = hold_full_i ? hold_data_i : sync_char_i;
      dlen    = CNT_W'(MIN_CHAR_BITS) + CNT_W'(char_len_i);
      frame   = '1;
      pos     = '0;
      par_acc = par_odd_i;
      if (!sync_mode_i) begin
         frame[0] = 1'b0;
         pos      = CNT_W'(1);
      end
      for (int i = 0; i < DATA_W; i++) begin
         if (CNT_W'(i) < dlen) begin
            frame[pos + CNT_W'(i)] = src[i];
            par_acc                = par_acc ^ src[i];
         end
      end
      pos = pos + dlen;
      if (par_en_i) begin
         frame[pos] = par_acc;
         pos        = pos + CNT_W'(1);
      end
      if (!sync_mode_i) pos = pos + (stop2_i ? CNT_W'(2) : CNT_W'(1));
      nbits = pos;
   end

   assign want   = hold_full_i || (sync_mode_i && gate_i);
   assign done   = busy_q && tick_i && (cnt_q == CNT_W'(1));
   assign load_o = want && (!busy_q || done);
   assign take_o = load_o && hold_full_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sreg_q    <= '1;
         cnt_q     <= '0;
         busy_q    <= 1'b0;
         is_data_q <= 1'b0;
      end else if (load_o) begin
         sreg_q    <= frame;
         cnt_q     <= nbits;
         busy_q    <= 1'b1;
         is_data_q <= hold_full_i;
      end else if (done) begin
         sreg_q    <= '1;
         cnt_q     <= '0;
         busy_q    <= 1'b0;
         is_data_q <= 1'b0;
      end else if (busy_q && tick_i) begin
         sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign txd_o       = busy_q ? sreg_q[0] : 1'b1;
   assign data_busy_o = busy_q && is_data_q;

endmodule

// File: rtl/usart_tx_core.sv
module usart_tx_core #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RATE_MID = 16,
   parameter int unsigned RATE_HI  = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              txc_i,
   input  logic              cts_n_i,
   input  logic              tx_en_i,
   input  logic              mode_sync_i,
   input  logic [1:0]        char_len_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              stop2_i,
   input  logic [1:0]        rate_sel_i,
   input  logic [DATA_W-1:0] sync_char_i,
   output logic              txd_o,
   output logic              tx_rdy_o,
   output logic              tx_empty_o
);

   if (DATA_W < 8) begin : g_bad_width
      $error("usart_tx_core: DATA_W must cover the 8-bit character length");
   end
   if (RATE_MID < 2 || RATE_HI <= RATE_MID) begin : g_bad_rate
      $error("usart_tx_core: rate factors must satisfy 1 < RATE_MID < RATE_HI");
   end

   logic              gate;
   logic              tick;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic              load;
   logic              data_busy;

   assign gate = tx_en_i && !cts_n_i;

   utx_rate_div #(
      .RATE_MID (RATE_MID),
      .RATE_HI  (RATE_HI)
   ) u_div (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .strobe_i    (txc_i),
      .restart_i   (load),
      .sync_mode_i (mode_sync_i),
      .rate_sel_i  (rate_sel_i),
      .tick_o      (tick)
   );

   utx_hold_buf #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .take_i    (take),
      .gate_i    (gate),
      .full_o    (hold_full),
      .data_o    (hold_data),
      .rdy_o     (tx_rdy_o)
   );

   utx_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .hold_full_i (hold_full),
      .hold_data_i (hold_data),
      .sync_mode_i (mode_sync_i),
      .gate_i      (gate),
      .sync_char_i (sync_char_i),
      .char_len_i  (char_len_i),
      .par_en_i    (par_en_i),
      .par_odd_i   (par_odd_i),
      .stop2_i     (stop2_i),
      .txd_o       (txd_o),
      .take_o      (take),
      .load_o      (load),
      .data_busy_o (data_busy)
   );

   assign tx_empty_o = !hold_full && !data_busy;

endmodule

// File: rtl/usart_tx_core_chk.sv
module usart_tx_core_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic wr_en_i,
   input logic cts_n_i,
   input logic tx_en_i,
   input logic mode_sync_i,
   input logic txd_o,
   input logic tx_rdy_o,
   input logic tx_empty_o
);

   AST_RDY_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_rdy_o |-> (tx_en_i && !cts_n_i)); // R2

   AST_EMPTY_GIVES_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_empty_o && tx_en_i && !cts_n_i) |-> tx_rdy_o); // R3

   AST_ACCEPT_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && tx_rdy_o) |=> !tx_empty_o); // R1

   AST_ASYNC_END_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_sync_i && $past(!mode_sync_i) && $rose(tx_empty_o)) |-> txd_o); // R4

endmodule

bind usart_tx_core usart_tx_core_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_en_i     (wr_en_i),
   .cts_n_i     (cts_n_i),
   .tx_en_i     (tx_en_i),
   .mode_sync_i (mode_sync_i),
   .txd_o       (txd_o),
   .tx_rdy_o    (tx_rdy_o),
   .tx_empty_o  (tx_empty_o)
);

// File: tb/usart_tx_core_tb_top.sv
module usart_tx_core_tb_top;

   typedef struct packed {
      logic [7:0] d;
      logic [1:0] cl;
      logic       pe;
      logic       po;
      logic       s2;
      logic [1:0] rs;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0},
      '{8'hA3, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0},
      '{8'h3C, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0},
      '{8'hC6, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3},
      '{8'h81, 2'd3, 1'b1, 1'b1, 1'b0, 2'd1},
      '{8'h2D, 2'd3, 1'b0, 1'b0, 1'b1, 2'd2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       txc = 1'b1;
   logic       cts_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       mode_sync = 1'b0;
   logic [1:0] char_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       stop2 = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic [7:0] sync_char = 8'h4B;
   logic       txd, tx_rdy, tx_empty;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5ns clk = ~clk;

   usart_tx_core dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .txc_i       (txc),
      .cts_n_i     (cts_n),
      .tx_en_i     (tx_en),
      .mode_sync_i (mode_sync),
      .char_len_i  (char_len),
      .par_en_i    (par_en),
      .par_odd_i   (par_odd),
      .stop2_i     (stop2),
      .rate_sel_i  (rate_sel),
      .sync_char_i (sync_char),
      .txd_o       (txd),
      .tx_rdy_o    (tx_rdy),
      .tx_empty_o  (tx_empty)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected line bits, bit 0 first; n returns the bit count
   function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] cl,
                                             input logic pe, input logic po, input logic s2,
                                             input logic sy, output int n);
      logic [11:0] f;
      int p;
      int len;
      logic par;
      f   = '1;
      p   = 0;
      len = 5 + int'(cl);
      par = po;
      if (!sy) begin f[0] = 1'b0; p = 1; end
      for (int i = 0; i < len; i++) begin
         f[p + i] = d[i];
         par      = par ^ d[i];
      end
      p = p + len;
      if (pe) begin f[p] = par; p++; end
      if (!sy) p = p + (s2 ? 2 : 1);
      n = p;
      return f;
   endfunction

   task automatic write_char(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // back-to-back pair in 8N1, with an optional disable after two bits
   task automatic pair_test(input logic [7:0] a, input logic [7:0] b, input int how);
      logic [19:0] stream;
      logic [19:0] expv;
      logic [11:0] fa, fb;
      int na, nb;
      mode_sync = 1'b0; char_len = 2'd3; par_en = 1'b0; stop2 = 1'b0; rate_sel = 2'd0;
      fa = exp_frame(a, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, na);
      fb = exp_frame(b, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, nb);
      for (int i = 0; i < 10; i++) begin
         expv[i]      = fa[i];
         expv[10 + i] = fb[i];
      end
      write_char(a);
      chk("R2 rdy low while buffer holds char", {31'd0, tx_rdy}, 32'd0);
      chk("R3 empty low after write", {31'd0, tx_empty}, 32'd0);
      @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         stream[i] = txd;
         if (i == 0) chk("R1 buffer freed on transfer", {31'd0, tx_rdy}, 32'd1);
         if (i == 1) chk("R2 rdy low after second write", {31'd0, tx_rdy}, 32'd0);
         wr_en   = (i == 0);
         wr_data = b;
         if (i == 2 && how == 1) cts_n = 1'b1;
         if (i == 2 && how == 2) tx_en = 1'b0;
         @(negedge clk);
      end
      if (how == 0) chk("R1 back-to-back frames", {12'd0, stream}, {12'd0, expv});
      else          chk("R9 written chars complete after disable", {12'd0, stream}, {12'd0, expv});
      repeat (3) @(negedge clk);
      chk("R3 empty after pair", {31'd0, tx_empty}, 32'd1);
      chk("R4 line idles high", {31'd0, txd}, 32'd1);
      if (how != 0) chk("R2 rdy stays low while disabled", {31'd0, tx_rdy}, 32'd0);
      cts_n = 1'b0;
      tx_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] f, cap;
      logic [23:0] sstream, sexp;
      logic [11:0] fs, fd;
      int n, fac;

      repeat (3) @(negedge clk);
      chk("R10 txd high in reset", {31'd0, txd}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 rdy low before enable", {31'd0, tx_rdy}, 32'd0);
      chk("R10 empty high after reset", {31'd0, tx_empty}, 32'd1);
      chk("R10 txd idle high", {31'd0, txd}, 32'd1);
      tx_en = 1'b1;
      @(negedge clk);
      chk("R2 rdy high once enabled", {31'd0, tx_rdy}, 32'd1);

      // vector table: frame format, parity, rate factor
      for (int v = 0; v < NVEC; v++) begin
         char_len = VECS[v].cl; par_en = VECS[v].pe; par_odd = VECS[v].po;
         stop2 = VECS[v].s2; rate_sel = VECS[v].rs;
         fac = (VECS[v].rs == 2'd1) ? 16 : (VECS[v].rs == 2'd2) ? 64 : 1;
         f   = exp_frame(VECS[v].d, VECS[v].cl, VECS[v].pe, VECS[v].po, VECS[v].s2, 1'b0, n);
         cap = '1;
         write_char(VECS[v].d);
         @(negedge clk);
         repeat (fac / 2) @(negedge clk);
         for (int i = 0; i < n; i++) begin
            cap[i] = txd;
            if (i < n - 1) repeat (fac) @(negedge clk);
         end
         // R4 R5 R6 frame compare
         chk($sformatf("R4/R5/R6 frame vector %0d", v), {20'd0, cap}, {20'd0, f});
         repeat (fac + 2) @(negedge clk);
         chk($sformatf("R3 empty after vector %0d", v), {31'd0, tx_empty}, 32'd1);
      end

      pair_test(8'h96, 8'h0F, 0);
      pair_test(8'h5A, 8'hE1, 1);
      pair_test(8'h33, 8'hC8, 2);

      // synchronous mode with fill; 16x selected but must not apply (R7)
      tx_en = 1'b0; mode_sync = 1'b1; rate_sel = 2'd1; char_len = 2'd3;
      par_en = 1'b0; sync_char = 8'h4B;
      repeat (2) @(negedge clk);
      chk("R8 sync idle high while disabled", {31'd0, txd}, 32'd1);
      tx_en = 1'b1;
      @(negedge clk);
      fs = exp_frame(8'h4B, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, n);
      fd = exp_frame(8'hB2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, n);
      for (int i = 0; i < 8; i++) begin
         sexp[i]      = fs[i];
         sexp[8 + i]  = fd[i];
         sexp[16 + i] = fs[i];
      end
      for (int i = 0; i < 24; i++) begin
         sstream[i] = txd;
         if (i == 0) chk("R3 empty high during sync fill", {31'd0, tx_empty}, 32'd1);
         if (i == 1) chk("R3 empty low with char pending", {31'd0, tx_empty}, 32'd0);
         wr_en   = (i == 0);
         wr_data = 8'hB2;
         @(negedge clk);
      end
      chk("R7 R8 sync fill, data, fill", {8'd0, sstream}, {8'd0, sexp});
      tx_en = 1'b0;
      repeat (12) @(negedge clk);
      chk("R8 line high after fill stops", {31'd0, txd}, 32'd1);
      chk("R3 empty when sync idle", {31'd0, tx_empty}, 32'd1);
      mode_sync = 1'b0; rate_sel = 2'd0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule